// File: doc/BRIEF.md
# PS/2 Device-to-Host Frame Receiver

This block takes the clock and data lines of a PS/2 port and recovers the bytes the attached device sends to the host. Both lines are open-drain with pull-ups. The receiver only listens and never pulls either line low. The block runs on a system clock many times faster than the 30 to 40 kHz PS/2 clock. The clock must be at least twice the PS/2 rate, and four times or more is better.

Each line passes through one synchronizing register. A four-state machine then follows the synchronized PS/2 clock. It has two level states (low and high) and two one-cycle marker states, one for each accepted edge. The data bit is captured in the falling-edge marker.

A single cycle counter serves as both the debounce timer and the inactivity watchdog. An edge is accepted only once the line has held its previous level for a set number of cycles. If the clock line stays high for a long window, any partial frame is dropped. This lets a device that is plugged in while the host runs line up with a frame boundary.

After the eleventh bit, the eight data bits appear on the byte output with a one-cycle done strobe. Parity is not checked.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, done_o is 0 and byte_o is 0x00.
- R2: A frame is 11 bits sent LSB first on falling PS/2 clock edges: a start bit (0), data bits 0 to 7, a parity bit and a stop bit (1). After the eleventh accepted falling edge, byte_o carries the eight data bits with bit 0 taken from the second frame bit.
- R3: done_o is high for exactly one system clock per completed frame. byte_o keeps its value until the next frame completes.
- R4: The parity bit is not checked. A frame with wrong parity is delivered like any other frame.
- R5: A level change on the synchronized PS/2 clock is accepted only after the line has held its previous level for at least DEBOUNCE_CYC system clocks since the last accepted edge. Glitches inside that window do not shift in bits.
- R6: If the PS/2 clock stays at the high level for WATCHDOG_CYC system clocks, the bit counter returns to zero. A partial frame is discarded without a strobe, and the next full frame is received correctly.
- R7: The machine leaves reset in its clock-low state. With the lines idle high it moves to clock-high without producing a strobe, and no extra reset pulse is needed before the first frame.
- R8: The data line is sampled only at accepted falling clock edges. Changes on the data line while the clock is low after that edge do not affect the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| kb_clk | input | 1 | PS/2 clock line as seen at the pad (open-drain, pulled up) |
| kb_dat | input | 1 | PS/2 data line as seen at the pad (open-drain, pulled up) |
| byte_o | output | 8 | Last received data byte |
| done_o | output | 1 | One-cycle strobe when a frame completes |

## Verification
The bench builds the receiver with DEBOUNCE_CYC = 4 and WATCHDOG_CYC = 40, and drives a PS/2 half period of 12 system clocks. With these values a whole frame takes a few hundred cycles. The watchdog window is longer than any high phase inside a frame but short enough that an idle gap trips it, so the hot-plug case becomes reachable. The debounce window is wide enough to place a one- or two-cycle glitch inside it right after each accepted edge. Frames with bad parity, data that changes during the low phase, back-to-back frames and a truncated frame followed by a clean one are all scored against a queue of expected bytes.

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
  parameter int DATA_BITS    = 8,
  parameter int DEBOUNCE_CYC = 62,
  parameter int WATCHDOG_CYC = 750
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 kb_clk,
  input  logic                 kb_dat,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 done_o
);
  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int SW = FRAME_BITS - 1;
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam int TW = $clog2(WATCHDOG_CYC + 1);

  typedef enum logic [1:0] {S_LOW = 2'd0, S_HIGH = 2'd1, S_FALL = 2'd2, S_RISE = 2'd3} st_t;

  logic          clk_s, dat_s;
  st_t           state, state_nx;
  logic [TW-1:0] tmr;
  logic [CW-1:0] bit_cnt;
  logic [SW-1:0] sh;

  wire settled  = tmr >= TW'(DEBOUNCE_CYC);
  wire idle_out = (state == S_HIGH) && (tmr == TW'(WATCHDOG_CYC));
  wire full     = bit_cnt == CW'(FRAME_BITS);

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      clk_s <= 1'b0;
      dat_s <= 1'b0;
    end else begin
      clk_s <= kb_clk;
      dat_s <= kb_dat;
    end

  always_comb begin
    state_nx = state;
    case (state)
      S_LOW:   if (clk_s && settled) state_nx = S_RISE;
      S_HIGH:  if (!clk_s && settled) state_nx = S_FALL;
      S_FALL:  state_nx = S_LOW;
      default: state_nx = S_HIGH;
    endcase
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) state <= S_LOW;
    else     state <= state_nx;

  always_ff @(posedge clk or posedge rst)
    if (rst)                                   tmr <= '0;
    else if (state == S_FALL || state == S_RISE) tmr <= '0;
    else if (tmr != TW'(WATCHDOG_CYC))           tmr <= tmr + TW'(1);

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else if (full || idle_out) begin
      bit_cnt <= '0;
    end else if (state == S_FALL) begin
      bit_cnt <= bit_cnt + CW'(1);
      sh      <= {dat_s, sh[SW-1:1]};
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      done_o <= 1'b0;
      byte_o <= '0;
    end else begin
      done_o <= full;
      if (full) byte_o <= sh[DATA_BITS-1:0];
    end

  // R3
  one_cycle_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(byte_o));

  // R5
  debounced_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_FALL) |-> ($past(state) == S_HIGH && $past(tmr) >= TW'(DEBOUNCE_CYC)));

  // R5
  debounced_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RISE) |-> ($past(state) == S_LOW && $past(tmr) >= TW'(DEBOUNCE_CYC)));

  // R6
  watchdog_clear_chk: assert property (@(posedge clk) disable iff (rst)
    idle_out |=> (bit_cnt == '0));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(FRAME_BITS));
endmodule

// File: tb/ps2_frame_rx_bench.sv
module ps2_frame_rx_bench;
  localparam int HALF = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic [7:0] byte_o;
  logic       done_o;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expq[$];
  logic prev_done = 1'b0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  ps2_frame_rx #(.DATA_BITS(8), .DEBOUNCE_CYC(4), .WATCHDOG_CYC(40)) u_ps2_frame_rx (
    .clk(clk), .rst(rst), .kb_clk(kb_clk), .kb_dat(kb_dat),
    .byte_o(byte_o), .done_o(done_o));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit bounce, input bit jitter);
    kb_dat = b;
    cyc(HALF);
    kb_clk = 1'b0;
    if (bounce) begin
      cyc(2); kb_clk = 1'b1; cyc(2); kb_clk = 1'b0; cyc(HALF - 4);
    end else if (jitter) begin
      cyc(HALF / 2); kb_dat = ~b; cyc(HALF - HALF / 2);
    end else cyc(HALF);
    kb_clk = 1'b1;
    if (bounce) begin
      cyc(2); kb_clk = 1'b0; cyc(2); kb_clk = 1'b1;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bounce, input bit jitter);
    logic [10:0] f;
    f = {1'b1, (~^d) ^ bad_par, d, 1'b0};
    expq.push_back(d);
    for (int i = 0; i < 11; i++) send_bit(f[i], bounce, jitter);
    kb_dat = 1'b1;
    cyc(HALF);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        if (prev_done) check("R3 strobe width", 32'd2, 32'd1);
        if (expq.size() == 0) check("R6/R7 unexpected strobe", {24'd0, byte_o}, 32'hFFFF_FFFF);
        else check("R2/R4/R5/R8 byte", {24'd0, byte_o}, {24'd0, expq.pop_front()});
      end
      prev_done <= done_o;
    end
  end

  initial begin
    cyc(200000);
    if (!finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset values
    check("R1 done in reset", {31'd0, done_o}, 32'd0);
    check("R1 byte in reset", {24'd0, byte_o}, 32'd0);
    rst = 1'b0;
    cyc(1);
    check("R1 done after reset", {31'd0, done_o}, 32'd0);
    check("R1 byte after reset", {24'd0, byte_o}, 32'd0);
    cyc(20);
    // R7 no strobe from idle start, first frame clean
    check("R7 idle no strobe", {31'd0, done_o}, 32'd0);
    send_frame(8'hA5, 0, 0, 0);
    cyc(10);
    check("R7 first frame delivered", expq.size(), 32'd0);
    // R2 patterns, back to back
    send_frame(8'h00, 0, 0, 0);
    send_frame(8'hFF, 0, 0, 0);
    send_frame(8'h81, 0, 0, 0);
    cyc(60);
    // R3 byte holds
    check("R3 byte holds", {24'd0, byte_o}, 32'h81);
    // R4 bad parity accepted
    send_frame(8'h3C, 1, 0, 0);
    send_frame(8'hC3, 1, 0, 0);
    // R5 glitches after each edge
    send_frame(8'h5A, 0, 1, 0);
    send_frame(8'h96, 0, 1, 0);
    // R8 data wiggles while clock low
    send_frame(8'h69, 0, 0, 1);
    send_frame(8'hE7, 0, 0, 1);
    // R6 truncated frame then idle beyond watchdog
    for (int i = 0; i < 4; i++) send_bit(i[0], 0, 0);
    kb_dat = 1'b1;
    cyc(80);
    send_frame(8'h42, 0, 0, 0);
    for (int i = 0; i < 7; i++) send_bit(1'b0, 0, 0);
    kb_dat = 1'b1;
    cyc(80);
    send_frame(8'h1E, 0, 0, 0);
    cyc(60);
    check("R6 all frames delivered", expq.size(), 32'd0);
    check("R3 final byte held", {24'd0, byte_o}, 32'h1E);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule